// File: doc/BRIEF.md
# PWM Action Qualifier with Software Force

This block sets the levels of two PWM outputs, A and B. A time-base counter that lives outside the block supplies a tick enable, the counter value, its direction, and strobes that mark when the counter is at zero and when it is at its period. The block holds two compare registers and compares each of them with the counter. From these it forms four events: zero, period, compare A while counting up, and compare B while counting up. Each channel has its own action word. The word gives every event a 2-bit code that leaves the output alone, drives it low, drives it high, or toggles it.

Software can also pin either output to a fixed level. Force settings are written into a shadow register. A reload selector decides when the shadow value becomes the active force: at the zero event, at the period event, at either of them, or at the next tick. While a force is active it takes precedence over every event action. When the force is released, the output keeps its level until an event acts on it again.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low, both compare registers hold 0, and the shadow and active force settings are both 00, so no force is applied.
- R2: The outputs and the active force change only on clock edges where `tick` is high.
- R3: The action word has four fields: zero event at [1:0], period event at [3:2], compare A at [5:4], compare B at [7:6]. The codes are 00 no change, 01 low, 10 high, 11 toggle.
- R4: A compare event fires on a tick when `count` equals that compare register and `count_up` is high. It never fires while `count_up` is low. Both channels see both compare events.
- R5: When `cmp_we[0]` (register A) or `cmp_we[1]` (register B) is high, that register loads `cmp_wdata` at the clock edge. Comparisons use the new value from the following cycle.
- R6: When several events occur in one tick, the first of them in the order compare B, compare A, period, zero that has a non-zero code decides the action.
- R7: Force bits [1:0] belong to channel A and [3:2] to channel B. 01 forces low, 10 forces high, and 00 or 11 means no force. An active force sets the output at every tick, whatever the events.
- R8: A `frc_we` write goes to the shadow register. The shadow is copied to the active force on a tick chosen by `reload_sel`: 00 at the zero event, 01 at the period event, 10 at either, 11 on every tick. The output follows the new active value on that same tick. A write on a reload tick lands after that tick's copy.
- R9: After a force is released, the output holds its last level until an event with a non-zero code acts on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base tick enable |
| at_zero | input | 1 | Counter is at zero (valid with tick) |
| at_period | input | 1 | Counter is at period (valid with tick) |
| count | input | CNT_W | Counter value |
| count_up | input | 1 | High while the counter counts up |
| cmp_we | input | 2 | Compare register write enables, bit 0 = A, bit 1 = B |
| cmp_wdata | input | CNT_W | Compare write data |
| act_a | input | 8 | Action word, channel A |
| act_b | input | 8 | Action word, channel B |
| frc_we | input | 1 | Force shadow write enable |
| frc_wdata | input | 4 | Force shadow write data |
| reload_sel | input | 2 | Force reload point |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The assertions assume that `at_zero` and `at_period` describe the same counter that drives `count`. They also assume that a cycle with `tick` low carries no event meaning. The down-count check further assumes that the only other way an output can move without a force is a zero or period strobe. The bench derives every strobe from its own counter, which steps only on ticks. It marks zero and period only at the true end points, and it lowers `count_up` only on the descending half of an up-down sweep, so the stimulus never strays outside these assumptions.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;

   localparam int ACT_W = 8;
   localparam int NCH   = 2;

   typedef enum logic [1:0] {
      ACT_NONE = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_TOG  = 2'b11
   } act_e;

   typedef struct packed {
      logic cb;
      logic ca;
      logic prd;
      logic zro;
   } evt_t;

   // first qualifying event in priority order cb > ca > prd > zro
   function automatic act_e pick_act(input logic [ACT_W-1:0] w, input evt_t e);
      act_e r;
      r = ACT_NONE;
      if (e.cb && w[7:6] != 2'b00)      r = act_e'(w[7:6]);
      else if (e.ca && w[5:4] != 2'b00) r = act_e'(w[5:4]);
      else if (e.prd && w[3:2] != 2'b00) r = act_e'(w[3:2]);
      else if (e.zro && w[1:0] != 2'b00) r = act_e'(w[1:0]);
      return r;
   endfunction

   function automatic logic apply_act(input act_e a, input logic cur);
      logic r;
      case (a)
         ACT_LOW:  r = 1'b0;
         ACT_HIGH: r = 1'b1;
         ACT_TOG:  r = ~cur;
         default:  r = cur;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pwmaq_cmp.sv
module pwmaq_cmp #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   input  logic             tick,
   input  logic [CNT_W-1:0] count,
   input  logic             count_up,
   output logic             hit
);

   logic [CNT_W-1:0] cmp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cmp_q <= '0;
      else if (we) cmp_q <= wdata;
   end

   assign hit = tick & count_up & (count == cmp_q);

endmodule

// File: rtl/pwmaq_force.sv
module pwmaq_force #(
   parameter int FRC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ev_zero,
   input  logic             ev_prd,
   input  logic [1:0]       reload_sel,
   input  logic             frc_we,
   input  logic [FRC_W-1:0] frc_wdata,
   output logic [FRC_W-1:0] frc_shd,
   output logic [FRC_W-1:0] frc_act,
   output logic [FRC_W-1:0] frc_nxt
);

   logic reload;

   always_comb begin
      case (reload_sel)
         2'b00:   reload = ev_zero;
         2'b01:   reload = ev_prd;
         2'b10:   reload = ev_zero | ev_prd;
         default: reload = tick;
      endcase
      frc_nxt = (tick && reload) ? frc_shd : frc_act;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frc_shd <= '0;
         frc_act <= '0;
      end else begin
         frc_act <= frc_nxt;
         if (frc_we) frc_shd <= frc_wdata;
      end
   end

endmodule

// File: rtl/pwmaq_chan.sv
module pwmaq_chan
   import pwmaq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  evt_t             evt,
   input  logic [ACT_W-1:0] act_word,
   input  logic [1:0]       frc_code,
   output logic             pwm
);

   logic pwm_d;

   always_comb begin
      pwm_d = pwm;
      if (tick) begin
         case (frc_code)
            2'b01:   pwm_d = 1'b0;
            2'b10:   pwm_d = 1'b1;
            default: pwm_d = apply_act(pick_act(act_word, evt), pwm);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm <= 1'b0;
      else        pwm <= pwm_d;
   end

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
   import pwmaq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             at_zero,
   input  logic             at_period,
   input  logic [CNT_W-1:0] count,
   input  logic             count_up,
   input  logic [1:0]       cmp_we,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic [ACT_W-1:0] act_a,
   input  logic [ACT_W-1:0] act_b,
   input  logic             frc_we,
   input  logic [3:0]       frc_wdata,
   input  logic [1:0]       reload_sel,
   output logic             pwm_a,
   output logic             pwm_b
);

   localparam int FRC_W = 2 * NCH;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("pwm_action_qual: CNT_W must lie in 2..32");
   end

   evt_t             evt;
   logic [NCH-1:0]   cmp_hit;
   logic [FRC_W-1:0] frc_shd;
   logic [FRC_W-1:0] frc_act;
   logic [FRC_W-1:0] frc_nxt;
   logic [NCH-1:0]   pwm_v;
   logic [ACT_W-1:0] act_w [NCH];

   assign act_w[0] = act_a;
   assign act_w[1] = act_b;

   for (genvar g = 0; g < NCH; g++) begin : g_cmp
      pwmaq_cmp #(.CNT_W(CNT_W)) u_cmp (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (cmp_we[g]),
         .wdata    (cmp_wdata),
         .tick     (tick),
         .count    (count),
         .count_up (count_up),
         .hit      (cmp_hit[g])
      );
   end

   always_comb begin
      evt.zro = tick & at_zero;
      evt.prd = tick & at_period;
      evt.ca  = cmp_hit[0];
      evt.cb  = cmp_hit[1];
   end

   pwmaq_force #(.FRC_W(FRC_W)) u_force (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .ev_zero    (evt.zro),
      .ev_prd     (evt.prd),
      .reload_sel (reload_sel),
      .frc_we     (frc_we),
      .frc_wdata  (frc_wdata),
      .frc_shd    (frc_shd),
      .frc_act    (frc_act),
      .frc_nxt    (frc_nxt)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      pwmaq_chan u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .evt      (evt),
         .act_word (act_w[g]),
         .frc_code (frc_nxt[2*g +: 2]),
         .pwm      (pwm_v[g])
      );
   end

   assign pwm_a = pwm_v[0];
   assign pwm_b = pwm_v[1];

endmodule

// File: rtl/pwmaq_chk.sv
module pwmaq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       at_zero,
   input logic       at_period,
   input logic       count_up,
   input logic [1:0] reload_sel,
   input logic [3:0] frc_shd,
   input logic [3:0] frc_act,
   input logic       pwm_a,
   input logic       pwm_b
);

   // R2
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

   // R2
   frc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(frc_act));

   // R7
   frc_low_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (frc_act[1:0] != 2'b01 || !pwm_a));

   // R7
   frc_high_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (frc_act[1:0] != 2'b10 || pwm_a));

   // R7
   frc_low_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (frc_act[3:2] != 2'b01 || !pwm_b));

   // R7
   frc_high_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (frc_act[3:2] != 2'b10 || pwm_b));

   // R8
   imm_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && reload_sel == 2'b11) |=> (frc_act == $past(frc_shd)));

   // R4
   no_down_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !count_up && !at_zero && !at_period && frc_act == 4'h0 && frc_shd == 4'h0)
      |=> ($stable(pwm_a) && $stable(pwm_b)));

endmodule

bind pwm_action_qual pwmaq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .at_zero    (at_zero),
   .at_period  (at_period),
   .count_up   (count_up),
   .reload_sel (reload_sel),
   .frc_shd    (frc_shd),
   .frc_act    (frc_act),
   .pwm_a      (pwm_a),
   .pwm_b      (pwm_b)
);

// File: tb/pwm_action_qual_test.sv
module pwm_action_qual_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        at_zero = 1'b0;
   logic        at_period = 1'b0;
   logic [15:0] count = '0;
   logic        count_up = 1'b0;
   logic [1:0]  cmp_we = '0;
   logic [15:0] cmp_wdata = '0;
   logic [7:0]  act_a = '0;
   logic [7:0]  act_b = '0;
   logic        frc_we = 1'b0;
   logic [3:0]  frc_wdata = '0;
   logic [1:0]  reload_sel = '0;
   logic        pwm_a;
   logic        pwm_b;

   int checks = 0;
   int errors = 0;
   string tag = "R1";

   // reference state
   logic [15:0] m_cmp [2];
   logic [3:0]  m_shd;
   logic [3:0]  m_act;
   logic        m_out [2];

   always #4 clk = ~clk;

   pwm_action_qual #(.CNT_W(16)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .at_zero    (at_zero),
      .at_period  (at_period),
      .count      (count),
      .count_up   (count_up),
      .cmp_we     (cmp_we),
      .cmp_wdata  (cmp_wdata),
      .act_a      (act_a),
      .act_b      (act_b),
      .frc_we     (frc_we),
      .frc_wdata  (frc_wdata),
      .reload_sel (reload_sel),
      .pwm_a      (pwm_a),
      .pwm_b      (pwm_b)
   );

   task automatic check(input logic got, input logic exp, input string req, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0b expected %0b at t=%0t", req, what, got, exp, $time);
      end
   endtask

   // reference model of one clock edge, built from the requirement text
   task automatic model_edge();
      logic ez, ep, ea, eb, rl;
      logic [1:0] f, code;
      logic [7:0] w;
      ez = tick && at_zero;
      ep = tick && at_period;
      ea = tick && count_up && (count == m_cmp[0]);
      eb = tick && count_up && (count == m_cmp[1]);
      if (tick) begin
         rl = (reload_sel == 2'd3) || (reload_sel == 2'd0 && ez) ||
              (reload_sel == 2'd1 && ep) || (reload_sel == 2'd2 && (ez || ep));
         if (rl) m_act = m_shd;
         for (int ch = 0; ch < 2; ch++) begin
            f = m_act[2*ch +: 2];
            w = (ch == 0) ? act_a : act_b;
            if (f == 2'd1) m_out[ch] = 1'b0;
            else if (f == 2'd2) m_out[ch] = 1'b1;
            else begin
               code = 2'd0;
               if (ez && w[1:0] != 0) code = w[1:0];
               if (ep && w[3:2] != 0) code = w[3:2];
               if (ea && w[5:4] != 0) code = w[5:4];
               if (eb && w[7:6] != 0) code = w[7:6];
               if (code == 2'd1) m_out[ch] = 1'b0;
               else if (code == 2'd2) m_out[ch] = 1'b1;
               else if (code == 2'd3) m_out[ch] = ~m_out[ch];
            end
         end
      end
      if (frc_we) m_shd = frc_wdata;
      if (cmp_we[0]) m_cmp[0] = cmp_wdata;
      if (cmp_we[1]) m_cmp[1] = cmp_wdata;
   endtask

   // inputs are set before the call, away from the rising edge
   task automatic step();
      string t;
      t = tick ? tag : "R2";
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(pwm_a, m_out[0], t, "pwm_a");
      check(pwm_b, m_out[1], t, "pwm_b");
      cmp_we = '0;
      frc_we = 1'b0;
   endtask

   task automatic idle();
      tick = 1'b0; at_zero = 1'b0; at_period = 1'b0;
      step();
   endtask

   // one counter period; optional force write on the first tick
   task automatic run_period(input int prd, input bit updown, input bit wr, input logic [3:0] wv);
      for (int c = 0; c <= prd; c++) begin
         tick = 1'b1; count = 16'(c); count_up = 1'b1;
         at_zero = (c == 0); at_period = (c == prd);
         if (wr && c == 0) begin frc_we = 1'b1; frc_wdata = wv; end
         step();
         if (c % 3 == 1) idle();
      end
      if (updown) begin
         for (int c = prd - 1; c >= 1; c--) begin
            tick = 1'b1; count = 16'(c); count_up = 1'b0;
            at_zero = 1'b0; at_period = 1'b0;
            step();
         end
      end
   endtask

   task automatic write_cmp(input int idx, input int val);
      cmp_we = (idx == 0) ? 2'b01 : 2'b10;
      cmp_wdata = 16'(val);
      idle();
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_cmp[0] = '0; m_cmp[1] = '0; m_shd = '0; m_act = '0;
      m_out[0] = 1'b0; m_out[1] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset levels
      check(pwm_a, 1'b0, "R1", "pwm_a reset");
      check(pwm_b, 1'b0, "R1", "pwm_b reset");
      // R1: immediate reload of the reset shadow must not force anything
      tag = "R1";
      reload_sel = 2'd3;
      act_a = 8'b00_00_10_00; act_b = 8'b00_00_00_11;
      run_period(3, 1'b0, 1'b0, 4'h0);

      // R3 R4 R6: every code on every event, compare sweep incl. coincidences
      tag = "R3 R4 R6";
      reload_sel = 2'd0;
      for (int p = 0; p <= 4; p += 4) begin
         for (int ca = 0; ca <= p + 1; ca++) begin
            tag = "R5";
            write_cmp(0, ca);
            write_cmp(1, (ca + 2) % (p + 2));
            tag = "R3 R4 R6";
            for (int k = 0; k < 64; k++) begin
               act_a = {2'b00, 6'(k)};
               act_b = {2'(k), 2'(k >> 4), 2'(k >> 2), 2'b01};
               run_period(p, 1'b0, 1'b0, 4'h0);
            end
         end
      end

      // R4: up-down sweep, compare must ignore the descending half
      tag = "R4";
      act_a = 8'b00_11_00_10;
      act_b = 8'b11_00_00_01;
      for (int c = 0; c <= 6; c++) begin
         write_cmp(0, c);
         write_cmp(1, 6 - c);
         run_period(5, 1'b1, 1'b0, 4'h0);
         run_period(5, 1'b1, 1'b0, 4'h0);
      end

      // R5: compare written during a tick is used from the next cycle
      tag = "R5";
      act_a = 8'b00_11_00_00; act_b = 8'b11_00_00_00;
      tick = 1'b1; count = 16'd2; count_up = 1'b1; at_zero = 1'b0; at_period = 1'b0;
      cmp_we = 2'b11; cmp_wdata = 16'd2;
      step();
      step();
      step();

      // R7 R8 R9: force codes, reload points, release
      act_a = 8'b00_01_10_10;
      act_b = 8'b00_00_00_11;
      write_cmp(0, 2);
      for (int sel = 0; sel < 4; sel++) begin
         reload_sel = 2'(sel);
         for (int fv = 0; fv < 16; fv++) begin
            tag = "R7 R8";
            frc_we = 1'b1; frc_wdata = 4'(fv);
            idle();
            run_period(4, 1'b0, 1'b0, 4'h0);
            run_period(4, 1'b1, 1'b0, 4'h0);
            tag = "R9";
            run_period(4, 1'b0, 1'b1, 4'h0);
            run_period(4, 1'b0, 1'b0, 4'h0);
            tag = "R8";
            run_period(3, 1'b0, 1'b1, 4'(15 - fv));
            run_period(3, 1'b0, 1'b1, 4'h0);
            run_period(3, 1'b0, 1'b0, 4'h0);
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule